// File: doc/BRIEF.md
# Multi-Mode Programmable Logic Cell

This block is one configurable cell for a fine-grained programmable fabric. Four data bits (`a`, `b`, `c`, `d`), a carry input and an enable come in. A single configuration word then chooses what the cell computes:

- any Boolean function of the four data bits, read from a 16-bit truth table;
- a one-bit full adder;
- one stage of an array multiplier;
- one bit of a binary counter;
- a two-way multiplexer that can drive a shared line.

Every mode produces a primary result and a carry result. The carry result is always combinational.

Three configuration flags act on the primary result:

- it can be taken from a flip-flop instead of straight from the logic;
- it can be driven through a tri-state buffer;
- the flip-flop content can be looped back in place of the `a` input.

Cells are chained through `carry_in`/`carry_out` to build adders, multiplier rows and counters.

The configuration word has these fields. Bits [15:0] are the truth table, with entry k at bit k. Bits [18:16] are the mode. Bit 19 is the register flag, bit 20 is the tri-state flag and bit 21 is the feedback flag.

Top module: `lcell_top`

## Requirements
- R1: In mode 0, the primary result is truth-table bit k, where k = {d,c,b,a} and `a` is the least significant bit. `carry_out` is 0.
- R2: In mode 1, the primary result is a^b^carry_in and `carry_out` is the majority of a, b and carry_in.
- R3: In mode 2, the partial product p = a&b is formed first. The primary result is p^c^carry_in and `carry_out` is the majority of p, c and carry_in.
- R4: In mode 3, the stored bit replaces `a` and the output is always registered. The stored bit inverts on each clock edge where carry_in is 1 and holds where it is 0. `carry_out` = stored bit & carry_in.
- R5: In mode 4, the primary result is b when c is 1 and a when c is 0. `carry_out` is 0. The output is driven only while `en` is 1, whatever the tri-state flag says.
- R6: Modes 5, 6 and 7 give a primary result of 0 and a `carry_out` of 0.
- R7: With the register flag set, `y` shows the primary result captured at the previous rising clock edge. `carry_out` stays combinational.
- R8: Outside mode 4, `y_drive` equals `en` when the tri-state flag is set and is 1 when it is clear. While `y_drive` is 0, `y` is high-impedance.
- R9: With the feedback flag set, the flip-flop content is used in place of the external `a` in every mode.
- R10: While `rst` is 1 at a rising edge, the flip-flop is cleared, so a registered `y` reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output flip-flop |
| cfg | input | 22 | Configuration word: table, mode and flags |
| a | input | 1 | Data input a (mux input when c=0) |
| b | input | 1 | Data input b (mux input when c=1) |
| c | input | 1 | Data input c (mux select in mode 4) |
| d | input | 1 | Data input d |
| carry_in | input | 1 | Carry from the previous cell |
| en | input | 1 | Tri-state enable |
| y | output | 1 | Primary output, may be high-impedance |
| y_drive | output | 1 | 1 while `y` is actively driven |
| carry_out | output | 1 | Combinational carry to the next cell |

## Verification
Every mode code, including the three unused ones, is swept through all 64 combinations of the data bits, carry and enable. Each sweep is repeated under all eight settings of the register, tri-state and feedback flags.

Three truth tables are used: all-zero, alternating bits, and a non-symmetric parity-like pattern. Together they catch a wrong index order or a swapped input in the table lookup.

The feedback and counter runs step the stored bit through sequences that depend on earlier cycles. This separates a loop taken from the flip-flop from a loop taken from the external input. A reset pulse part-way through a registered run shows that clearing happens at the clock edge.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int CELL_IN   = 4;
  localparam int LUT_DEPTH = 1 << CELL_IN;
  localparam int MODE_W    = 3;
  localparam int CFG_W     = LUT_DEPTH + MODE_W + 3;
  localparam int MODE_LSB  = LUT_DEPTH;
  localparam int REG_BIT   = LUT_DEPTH + MODE_W;
  localparam int TRI_BIT   = REG_BIT + 1;
  localparam int FB_BIT    = REG_BIT + 2;

  typedef enum logic [MODE_W-1:0] {
    M_LUT   = 3'd0,
    M_ADD   = 3'd1,
    M_MULT  = 3'd2,
    M_COUNT = 3'd3,
    M_MUX   = 3'd4
  } mode_e;
endpackage

// File: rtl/lcell_in_sel.sv
module lcell_in_sel (
  input  logic ext_a,
  input  logic stored,
  input  logic use_fb,
  output logic a_eff
);
  always_comb a_eff = use_fb ? stored : ext_a;
endmodule

// File: rtl/lcell_func.sv
module lcell_func
  import lcell_pkg::*;
(
  input  logic [MODE_W-1:0]    mode,
  input  logic [LUT_DEPTH-1:0] table_bits,
  input  logic [CELL_IN-1:0]   din,
  input  logic                 cin,
  output logic                 f_out,
  output logic                 f_carry
);
  logic pp;

  always_comb begin
    pp      = din[0] & din[1];
    f_out   = 1'b0;
    f_carry = 1'b0;
    case (mode)
      M_LUT:   f_out = table_bits[din];
      M_ADD: begin
        f_out   = din[0] ^ din[1] ^ cin;
        f_carry = (din[0] & din[1]) | (cin & (din[0] | din[1]));
      end
      M_MULT: begin
        f_out   = pp ^ din[2] ^ cin;
        f_carry = (pp & din[2]) | (cin & (pp | din[2]));
      end
      M_COUNT: begin
        f_out   = din[0] ^ cin;
        f_carry = din[0] & cin;
      end
      M_MUX:   f_out = din[2] ? din[1] : din[0];
      default: begin
        f_out   = 1'b0;
        f_carry = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lcell_out.sv
module lcell_out (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic reg_sel,
  input  logic oe,
  output logic q,
  output logic drive,
  output logic y
);
  logic prim;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  always_comb prim = reg_sel ? q : d;
  assign drive = oe;
  assign y     = oe ? prim : 1'bz;

  // R7
  reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             a,
  input  logic             b,
  input  logic             c,
  input  logic             d,
  input  logic             carry_in,
  input  logic             en,
  output logic             y,
  output logic             y_drive,
  output logic             carry_out
);
  logic [MODE_W-1:0] mode;
  logic is_count, is_mux, use_fb, reg_sel, oe;
  logic a_eff, q, f_out;

  assign mode     = cfg[MODE_LSB +: MODE_W];
  assign is_count = (mode == M_COUNT);
  assign is_mux   = (mode == M_MUX);
  assign use_fb   = cfg[FB_BIT]  | is_count;
  assign reg_sel  = cfg[REG_BIT] | is_count;
  assign oe       = (cfg[TRI_BIT] | is_mux) ? en : 1'b1;

  lcell_in_sel u_sel (
    .ext_a (a),
    .stored(q),
    .use_fb(use_fb),
    .a_eff (a_eff)
  );

  lcell_func u_func (
    .mode      (mode),
    .table_bits(cfg[LUT_DEPTH-1:0]),
    .din       ({d, c, b, a_eff}),
    .cin       (carry_in),
    .f_out     (f_out),
    .f_carry   (carry_out)
  );

  lcell_out u_out (
    .clk  (clk),
    .rst  (rst),
    .d    (f_out),
    .reg_sel(reg_sel),
    .oe   (oe),
    .q    (q),
    .drive(y_drive),
    .y    (y)
  );

  // R10
  sync_clear_chk: assert property (@(posedge clk) rst |=> (q == 1'b0));

  // R4
  count_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (is_count && carry_in) |=> (q != $past(q)));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (is_count && !carry_in) |=> $stable(q));

  // R5
  mux_release_chk: assert property (@(posedge clk) disable iff (rst)
    (is_mux && !en) |-> !y_drive);

  // R8
  always_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg[TRI_BIT] && !is_mux) |-> y_drive);

  // R6
  unused_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode > 3'd4) |-> (!carry_out && !f_out));
endmodule

// File: tb/lcell_top_bench.sv
module lcell_top_bench;
  import lcell_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CFG_W-1:0] cfg = '0;
  logic a = 0, b = 0, c = 0, d = 0, carry_in = 0, en = 0;
  logic y, y_drive, carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic mq = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcell_top u_lcell_top (
    .clk(clk), .rst(rst), .cfg(cfg), .a(a), .b(b), .c(c), .d(d),
    .carry_in(carry_in), .en(en), .y(y), .y_drive(y_drive),
    .carry_out(carry_out)
  );

  function automatic logic [1:0] model(input logic [2:0] m,
                                       input logic [15:0] tb,
                                       input logic ia, ib, ic, id, ci);
    logic p;
    p = ia & ib;
    case (m)
      3'd0: return {1'b0, tb[{id, ic, ib, ia}]};
      3'd1: return {(ia & ib) | (ci & (ia | ib)), ia ^ ib ^ ci};
      3'd2: return {(p & ic) | (ci & (p | ic)), p ^ ic ^ ci};
      3'd3: return {ia & ci, ia ^ ci};
      3'd4: return {1'b0, ic ? ib : ia};
      default: return 2'b00;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (cfg=%h a%b b%b c%b d%b ci%b en%b)",
               tag, act, exp, cfg, a, b, c, d, carry_in, en);
    end
  endtask

  // Drives inputs at the falling edge, checks, then advances one clock.
  task automatic step(input logic [2:0] m, input logic [15:0] tb,
                      input logic rg, tri_f, fb,
                      input logic [5:0] ins, input logic r);
    logic [1:0] e;
    logic ia, fb_eff, rg_eff, drv;
    string tag;
    @(negedge clk);
    cfg = {fb, tri_f, rg, m, tb};
    {en, carry_in, d, c, b, a} = ins;
    rst = r;
    #1;
    fb_eff = fb | (m == 3'd3);
    rg_eff = rg | (m == 3'd3);
    ia = fb_eff ? mq : ins[0];
    e = model(m, tb, ia, ins[1], ins[2], ins[3], ins[4]);
    drv = ((m == 3'd4) || tri_f) ? ins[5] : 1'b1;
    tag = fb ? "R9" : mode_tag(m);
    check(tag, carry_out, e[1]);
    check((m == 3'd4) ? "R5" : "R8", y_drive, drv);
    if (drv) check(rg_eff ? "R7" : tag, y, rg_eff ? mq : e[0]);
    @(posedge clk);
    mq = r ? 1'b0 : e[0];
  endtask

  initial begin
    logic [15:0] tables [3];
    tables[0] = 16'h0000;
    tables[1] = 16'hAAAA;
    tables[2] = 16'h6C93;
    repeat (2) @(posedge clk);
    mq = 1'b0;
    for (int fl = 0; fl < 8; fl++)
      for (int m = 0; m < 8; m++)
        for (int t = 0; t < 3; t++)
          for (int i = 0; i < 64; i++)
            step(3'(m), tables[t], fl[0], fl[1], fl[2], 6'(i), 1'b0);
    // R10: reset mid-run with registered table output of all ones
    step(3'd0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 6'h00, 1'b0);
    step(3'd0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 6'h00, 1'b1);
    #1 check("R10", y, 1'b0);
    step(3'd0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 6'h00, 1'b0);
    #1 check("R10", y, 1'b1);
    // R4: counter run from a cleared bit, carry held high for 5 edges
    step(3'd3, 16'h0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b1);
    for (int k = 0; k < 5; k++)
      step(3'd3, 16'h0, 1'b0, 1'b0, 1'b0, 6'h10, 1'b0);
    #1 check("R4", y, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule